// File: doc/BRIEF.md
# Overcurrent and Short-Circuit Fault Sequencer

This block is the digital protection sequencer of a switching regulator. It watches per-cycle comparator flags (peak current limit, output undervoltage, output overvoltage, overtemperature) together with a soft-start completion flag. It decides whether the power stage may switch, whether the soft-start ramp must be held in reset, whether the output must be actively discharged, and whether a fault is reported. All analog sensing and the ramp itself sit outside the block. Only the digital flags are sequenced.

Current-limit events are counted on consecutive switching cycles, one per `cyc_tick`. A register-selected window length decides when sustained limiting counts as a short circuit. Undervoltage seen together with the current limit skips the window and trips at once. The short-circuit response can be a hiccup restart loop, continued switching with a fault report, or latch-off. Overvoltage has its own selectable response.

Top module: `ocp_fault_seq`

## Requirements
- R1: While `rst_n` is low, and while `en` is low after reset, the outputs are `pwr_en`=0, `ss_reset`=1, `dischg`=0 and `fault`=0.
- R2: One clock after `en` is sampled high in the idle phase, the block enters soft-start (`pwr_en`=1, `ss_reset`=0). It moves to the run phase on the clock edge that samples `ss_done` high. Current-limit counting happens only in the run phase.
- R3: In the run phase, every `cyc_tick` with `ilim_hit` high adds one to the count. A short-circuit trip occurs on the tick where the count would reach or pass the window length. `ocp_len_sel` encodes the length: 0=32, 1=64, 2=128, 3=256 ticks.
- R4: A `cyc_tick` with `ilim_hit` low clears the count, so no trip occurs until a full new window of current-limited ticks has passed.
- R5: A run-phase `cyc_tick` with both `ilim_hit` and `uv_flag` high trips at once, whatever the count.
- R6: `scp_mode` 0 or 3 selects hiccup. After a trip, the block sets `pwr_en`=0, `ss_reset`=1 and `fault`=1 for max(1,`hiccup_off`) ticks, then re-enters soft-start. The loop repeats while the fault persists.
- R7: `scp_mode`=1 selects continued switching. After a trip, `pwr_en` stays 1 and `fault`=1 until a tick without `ilim_hit` or until the run phase is left.
- R8: `scp_mode`=2 selects latch-off. After a trip, the outputs are `pwr_en`=0, `ss_reset`=1 and `fault`=1. They hold until `en` goes low or reset, and no other input releases them.
- R9: `ovp_mode` sets the overvoltage response. 0 or 3 means `ov_flag` has no effect. 1 gives `dischg`=1, `pwr_en`=0 and `fault`=1 one clock after each cycle `ov_flag` is high. 2 latches off as in R8. An overvoltage latch takes priority over overtemperature and short-circuit handling.
- R10: `ot_flag` high, when not latched, returns the block to idle (`pwr_en`=0, `ss_reset`=1, `fault`=1) one clock later. After it clears, a fresh soft-start follows.
- R11: `en` low forces idle on the next clock from any state, latch-off included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Converter enable; low clears all state |
| cyc_tick | input | 1 | One-clock pulse per switching cycle |
| ilim_hit | input | 1 | Peak current limit reached this cycle |
| uv_flag | input | 1 | Output undervoltage comparator |
| ov_flag | input | 1 | Output overvoltage comparator |
| ot_flag | input | 1 | Overtemperature comparator |
| ss_done | input | 1 | Soft-start ramp has finished |
| ocp_len_sel | input | 2 | Current-limit window length select |
| scp_mode | input | 2 | Short-circuit response select |
| ovp_mode | input | 2 | Overvoltage response select |
| hiccup_off | input | 8 | Hiccup off-time in switching cycles |
| pwr_en | output | 1 | Power stage may switch |
| ss_reset | output | 1 | Hold the soft-start ramp in reset |
| dischg | output | 1 | Actively discharge the output |
| fault | output | 1 | Fault indication, active high |

## Verification
Every output is decoded from registered state, so any wrong internal state reaches the ports no later than the next clock. The one exception is the current-limit count, which shows up only as a trip. A count that is off by one or is not cleared moves the trip by a cycle, or makes it appear or vanish. The reference model catches that on the exact cycle `pwr_en` or `fault` should change. A wrong hiccup counter likewise shows as soft-start resuming a tick early or late.

// File: rtl/ocp_fault_pkg.sv
`timescale 1ns/1ps
// Shared types for the fault sequencer: phase encoding and mode codes.
// Assumes two-bit mode fields; unused codes fall back to the default response.
package ocp_fault_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SOFT  = 3'd1,
        ST_RUN   = 3'd2,
        ST_HOFF  = 3'd3,
        ST_LATCH = 3'd4
    } seq_state_t;

    localparam logic [1:0] SCP_HICCUP = 2'd0;
    localparam logic [1:0] SCP_CONT   = 2'd1;
    localparam logic [1:0] SCP_LATCH  = 2'd2;

    localparam logic [1:0] OVP_IGNORE = 2'd0;
    localparam logic [1:0] OVP_DISCH  = 2'd1;
    localparam logic [1:0] OVP_LATCH  = 2'd2;

endpackage

// File: rtl/ocp_cycle_counter.sv
`timescale 1ns/1ps
// Counts consecutive current-limited switching cycles and raises a one-clock
// trip when the selected window is filled or undervoltage accompanies the limit.
// Assumes cyc_tick is a single-clock pulse; counting only while arm is high.
module ocp_cycle_counter #(
    parameter int BASE_LOG2 = 5,
    parameter int SEL_W     = 2,
    localparam int NUM_LEN  = 1 << SEL_W,
    localparam int CNT_W    = BASE_LOG2 + NUM_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             tick,
    input  logic             ilim,
    input  logic             uv,
    input  logic [SEL_W-1:0] len_sel,
    output logic             trip,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] len_tbl [NUM_LEN];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] win_len;

    // Window lengths double with each select step.
    for (genvar g = 0; g < NUM_LEN; g++) begin : g_len
        assign len_tbl[g] = {{(CNT_W-1){1'b0}}, 1'b1} << (BASE_LOG2 + g);
    end

    assign win_len = len_tbl[len_sel];
    assign cnt_inc = cnt_q + 1'b1;

    // Trip on a limited tick that fills the window or coincides with undervoltage.
    always_comb begin
        trip = arm && tick && ilim && (uv || (cnt_inc >= win_len));
    end

    // Count limited ticks; clear on a clean tick, on trip, or when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (ilim && !trip) ? cnt_inc : '0;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/hiccup_timer.sv
`timescale 1ns/1ps
// Off-time timer of the hiccup loop: loaded on entry, counts switching ticks,
// flags the final tick. A loaded value of 0 behaves as 1.
module hiccup_timer #(
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFF_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic             done
);

    logic [OFF_W-1:0] rem_q;

    // Last tick of the off period.
    always_comb begin
        done = run && tick && (rem_q <= OFF_W'(1));
    end

    // Load on entry, then step down once per tick while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (run && tick && (rem_q > OFF_W'(1))) begin
            rem_q <= rem_q - 1'b1;
        end
    end

endmodule

// File: rtl/ov_ot_monitor.sv
`timescale 1ns/1ps
// Registers the overvoltage-discharge and overtemperature conditions and
// decodes an overvoltage latch request. Assumes comparator flags are synchronous.
module ov_ot_monitor
    import ocp_fault_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       ov_flag,
    input  logic       ot_flag,
    input  logic [1:0] ovp_mode,
    output logic       dis_act,
    output logic       ot_act,
    output logic       ov_latch_req
);

    logic dis_q;
    logic ot_q;

    // Latch-off request goes straight to the sequencer.
    always_comb begin
        ov_latch_req = ov_flag && (ovp_mode == OVP_LATCH);
    end

    // Track active discharge and overtemperature for one clock per sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= 1'b0;
            ot_q  <= 1'b0;
        end else begin
            dis_q <= en && ov_flag && (ovp_mode == OVP_DISCH);
            ot_q  <= en && ot_flag;
        end
    end

    assign dis_act = dis_q;
    assign ot_act  = ot_q;

endmodule

// File: rtl/fault_seq_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: idle, soft-start, run, hiccup-off and latch-off, plus the
// continued-switching fault flag. Priority: enable, latch, OV latch, OT, phase.
module fault_seq_fsm
    import ocp_fault_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       ilim,
    input  logic       ss_done,
    input  logic       ot,
    input  logic       ov_latch_req,
    input  logic       trip,
    input  logic       hic_done,
    input  logic [1:0] scp_mode,
    output seq_state_t state,
    output logic       sc_cont,
    output logic       load_off
);

    seq_state_t st_q, st_n;
    logic       sc_q, sc_n;
    logic       stay_run;

    // Next phase selection in priority order.
    always_comb begin
        st_n = st_q;
        if (!en) begin
            st_n = ST_IDLE;
        end else if (st_q == ST_LATCH) begin
            st_n = ST_LATCH;
        end else if (ov_latch_req) begin
            st_n = ST_LATCH;
        end else if (ot) begin
            st_n = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: st_n = ST_SOFT;
                ST_SOFT: if (ss_done) st_n = ST_RUN;
                ST_RUN: begin
                    if (trip) begin
                        if (scp_mode == SCP_LATCH)     st_n = ST_LATCH;
                        else if (scp_mode == SCP_CONT) st_n = ST_RUN;
                        else                           st_n = ST_HOFF;
                    end
                end
                ST_HOFF: if (hic_done) st_n = ST_SOFT;
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // Continued-switching fault flag lives only inside the run phase.
    always_comb begin
        stay_run = (st_q == ST_RUN) && (st_n == ST_RUN);
        sc_n     = stay_run && ((trip && (scp_mode == SCP_CONT)) ||
                                (sc_q && !(tick && !ilim)));
        load_off = (st_q == ST_RUN) && (st_n == ST_HOFF);
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            sc_q <= 1'b0;
        end else begin
            st_q <= st_n;
            sc_q <= sc_n;
        end
    end

    assign state   = st_q;
    assign sc_cont = sc_q;

endmodule

// File: rtl/ocp_fault_seq.sv
`timescale 1ns/1ps
// Top of the protection sequencer: counts current-limited cycles, runs the
// short-circuit and overvoltage responses and decodes the power-stage controls.
// Assumes all flags are synchronous to clk and cyc_tick pulses once per cycle.
module ocp_fault_seq
    import ocp_fault_pkg::*;
#(
    parameter int BASE_LOG2 = 5,
    parameter int SEL_W     = 2,
    parameter int OFF_W     = 8,
    localparam int NUM_LEN  = 1 << SEL_W,
    localparam int CNT_W    = BASE_LOG2 + NUM_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cyc_tick,
    input  logic             ilim_hit,
    input  logic             uv_flag,
    input  logic             ov_flag,
    input  logic             ot_flag,
    input  logic             ss_done,
    input  logic [SEL_W-1:0] ocp_len_sel,
    input  logic [1:0]       scp_mode,
    input  logic [1:0]       ovp_mode,
    input  logic [OFF_W-1:0] hiccup_off,
    output logic             pwr_en,
    output logic             ss_reset,
    output logic             dischg,
    output logic             fault
);

    seq_state_t       state_q;
    logic             sc_cont;
    logic             load_off;
    logic             trip;
    logic             hic_done;
    logic             dis_act;
    logic             ot_act;
    logic             ov_latch_req;
    logic [CNT_W-1:0] ocp_cnt;

    ocp_cycle_counter #(
        .BASE_LOG2 (BASE_LOG2),
        .SEL_W     (SEL_W)
    ) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (state_q == ST_RUN),
        .tick    (cyc_tick),
        .ilim    (ilim_hit),
        .uv      (uv_flag),
        .len_sel (ocp_len_sel),
        .trip    (trip),
        .cnt     (ocp_cnt)
    );

    hiccup_timer #(
        .OFF_W (OFF_W)
    ) i_hic (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_off),
        .load_val (hiccup_off),
        .run      (state_q == ST_HOFF),
        .tick     (cyc_tick),
        .done     (hic_done)
    );

    ov_ot_monitor i_mon (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .ov_flag      (ov_flag),
        .ot_flag      (ot_flag),
        .ovp_mode     (ovp_mode),
        .dis_act      (dis_act),
        .ot_act       (ot_act),
        .ov_latch_req (ov_latch_req)
    );

    fault_seq_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .tick         (cyc_tick),
        .ilim         (ilim_hit),
        .ss_done      (ss_done),
        .ot           (ot_flag),
        .ov_latch_req (ov_latch_req),
        .trip         (trip),
        .hic_done     (hic_done),
        .scp_mode     (scp_mode),
        .state        (state_q),
        .sc_cont      (sc_cont),
        .load_off     (load_off)
    );

    // Decode the power-stage controls from registered state.
    always_comb begin
        pwr_en   = ((state_q == ST_SOFT) || (state_q == ST_RUN)) && !dis_act;
        ss_reset = (state_q == ST_IDLE) || (state_q == ST_HOFF) || (state_q == ST_LATCH);
        dischg   = dis_act;
        fault    = (state_q == ST_LATCH) || (state_q == ST_HOFF) || sc_cont || dis_act || ot_act;
    end

endmodule

// File: rtl/ocp_fault_seq_chk.sv
`timescale 1ns/1ps
// Property checker for the sequencer, bound to the top module below.
module ocp_fault_seq_chk
    import ocp_fault_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             cyc_tick,
    input logic             ilim_hit,
    input logic             uv_flag,
    input logic             ov_flag,
    input logic             ot_flag,
    input logic [1:0]       scp_mode,
    input logic [1:0]       ovp_mode,
    input logic             pwr_en,
    input logic             dischg,
    input seq_state_t       st,
    input logic [CNT_W-1:0] cnt,
    input logic             sc_cont
);

    localparam logic [CNT_W-1:0] MAX_LEN = {1'b1, {(CNT_W-1){1'b0}}};

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < MAX_LEN);

    p_uv_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == ST_RUN && cyc_tick && ilim_hit && uv_flag && !ov_flag &&
         !ot_flag && scp_mode == SCP_HICCUP) |=> (st == ST_HOFF));

    p_hoff_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == ST_HOFF && !cyc_tick && !ot_flag && !ov_flag) |=> (st == ST_HOFF));

    p_cont_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sc_cont |-> (st == ST_RUN));

    p_latch_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == ST_LATCH) |=> (st == ST_LATCH));

    p_ov_discharge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ov_flag && ovp_mode == OVP_DISCH) |=> (dischg && !pwr_en));

    p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st == ST_IDLE && !pwr_en));

endmodule

bind ocp_fault_seq ocp_fault_seq_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cyc_tick (cyc_tick),
    .ilim_hit (ilim_hit),
    .uv_flag  (uv_flag),
    .ov_flag  (ov_flag),
    .ot_flag  (ot_flag),
    .scp_mode (scp_mode),
    .ovp_mode (ovp_mode),
    .pwr_en   (pwr_en),
    .dischg   (dischg),
    .st       (state_q),
    .cnt      (ocp_cnt),
    .sc_cont  (sc_cont)
);

// File: tb/test_ocp_fault_seq.sv
`timescale 1ns/1ps
// Bench: behavioural reference model advanced on every rising edge,
// outputs compared at every falling edge.
module test_ocp_fault_seq;

    localparam int P_IDLE = 0, P_SOFT = 1, P_RUN = 2, P_HOFF = 3, P_LATCH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cyc_tick = 1'b0;
    logic       ilim_hit = 1'b0;
    logic       uv_flag = 1'b0;
    logic       ov_flag = 1'b0;
    logic       ot_flag = 1'b0;
    logic       ss_done = 1'b0;
    logic [1:0] ocp_len_sel = 2'd0;
    logic [1:0] scp_mode = 2'd0;
    logic [1:0] ovp_mode = 2'd0;
    logic [7:0] hiccup_off = 8'd3;
    logic       pwr_en, ss_reset, dischg, fault;

    int    vecs = 0;
    int    fails = 0;
    int    cyc = 0;
    int    tick_div = 1;
    string cur_req = "R1";

    int m_st = P_IDLE, m_cnt = 0, m_off = 0;
    bit m_sc = 0, m_dis = 0, m_ot = 0;

    always #5 clk = ~clk;

    ocp_fault_seq i_ocp_fault_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .cyc_tick    (cyc_tick),
        .ilim_hit    (ilim_hit),
        .uv_flag     (uv_flag),
        .ov_flag     (ov_flag),
        .ot_flag     (ot_flag),
        .ss_done     (ss_done),
        .ocp_len_sel (ocp_len_sel),
        .scp_mode    (scp_mode),
        .ovp_mode    (ovp_mode),
        .hiccup_off  (hiccup_off),
        .pwr_en      (pwr_en),
        .ss_reset    (ss_reset),
        .dischg      (dischg),
        .fault       (fault)
    );

    // Reference model written from the requirements.
    always @(posedge clk) begin : model
        int len, nst, ncnt, noff;
        bit trip, hdone, nsc;
        if (!rst_n) begin
            m_st = P_IDLE; m_cnt = 0; m_off = 0; m_sc = 0; m_dis = 0; m_ot = 0;
        end else begin
            len   = 32 << ocp_len_sel;
            trip  = (m_st == P_RUN) && cyc_tick && ilim_hit && (uv_flag || (m_cnt + 1 >= len));
            hdone = (m_st == P_HOFF) && cyc_tick && (m_off <= 1);
            if (m_st != P_RUN) ncnt = 0;
            else if (cyc_tick) ncnt = (ilim_hit && !trip) ? m_cnt + 1 : 0;
            else ncnt = m_cnt;
            nst = m_st;
            if (!en) nst = P_IDLE;
            else if (m_st == P_LATCH) nst = P_LATCH;
            else if (ov_flag && ovp_mode == 2) nst = P_LATCH;
            else if (ot_flag) nst = P_IDLE;
            else if (m_st == P_IDLE) nst = P_SOFT;
            else if (m_st == P_SOFT) begin if (ss_done) nst = P_RUN; end
            else if (m_st == P_RUN) begin
                if (trip) nst = (scp_mode == 2) ? P_LATCH : (scp_mode == 1) ? P_RUN : P_HOFF;
            end
            else if (m_st == P_HOFF) begin if (hdone) nst = P_SOFT; end
            noff = m_off;
            if (m_st == P_RUN && nst == P_HOFF) noff = hiccup_off;
            else if (m_st == P_HOFF && cyc_tick && m_off > 1) noff = m_off - 1;
            nsc = (m_st == P_RUN && nst == P_RUN) &&
                  ((trip && scp_mode == 1) || (m_sc && !(cyc_tick && !ilim_hit)));
            m_dis = en && ov_flag && ovp_mode == 1;
            m_ot  = en && ot_flag;
            m_st = nst; m_cnt = ncnt; m_off = noff; m_sc = nsc;
        end
    end

    // Compare the four outputs against the model.
    task automatic compare();
        logic [3:0] exp, act;
        exp[3] = (m_st == P_SOFT || m_st == P_RUN) && !m_dis;
        exp[2] = (m_st == P_IDLE || m_st == P_HOFF || m_st == P_LATCH);
        exp[1] = m_dis;
        exp[0] = (m_st == P_LATCH) || (m_st == P_HOFF) || m_sc || m_dis || m_ot;
        act = {pwr_en, ss_reset, dischg, fault};
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: {pwr_en,ss_reset,dischg,fault} got %b expected %b",
                     cur_req, cyc, act, exp);
        end
    endtask

    // Advance n clocks; check after each and set the next tick.
    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            compare();
            cyc_tick = ((cyc % tick_div) == 0);
        end
    endtask

    initial begin : watchdog
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin : stimulus
        cur_req = "R1";  step(3);
        rst_n = 1'b1;    step(2);
        cur_req = "R2";  en = 1'b1; step(3);
        ss_done = 1'b1;  step(2);
        // R4: a clean tick inside the window restarts the count
        cur_req = "R4"; ocp_len_sel = 2'd0; ilim_hit = 1'b1; step(31);
        ilim_hit = 1'b0; step(1);
        ilim_hit = 1'b1; step(31);
        // R3 and R6: the 32nd limited tick trips into hiccup
        cur_req = "R3"; step(2);
        cur_req = "R6"; ilim_hit = 1'b0; hiccup_off = 8'd4; tick_div = 3; step(24);
        hiccup_off = 8'd0; ilim_hit = 1'b1; tick_div = 1; step(40);
        ilim_hit = 1'b0; step(4);
        // R7: continued switching with the 128-tick window
        cur_req = "R7"; scp_mode = 2'd1; ocp_len_sel = 2'd2; ilim_hit = 1'b1; step(140);
        ilim_hit = 1'b0; step(3);
        // R5 and R8: undervoltage trips at once and latches off
        cur_req = "R5"; scp_mode = 2'd2; ilim_hit = 1'b1; uv_flag = 1'b1; step(1);
        cur_req = "R8"; uv_flag = 1'b0; ilim_hit = 1'b0; ss_done = 1'b1; step(6);
        cur_req = "R11"; en = 1'b0; step(2);
        en = 1'b1; step(4);
        // R9: overvoltage discharge, ignore and latch
        cur_req = "R9"; ovp_mode = 2'd1; ov_flag = 1'b1; step(4);
        ov_flag = 1'b0; step(3);
        ovp_mode = 2'd0; ov_flag = 1'b1; step(3);
        ovp_mode = 2'd2; step(3);
        ov_flag = 1'b0; step(3);
        en = 1'b0; step(1);
        en = 1'b1; ovp_mode = 2'd0; step(4);
        // R10: overtemperature stop and restart
        cur_req = "R10"; ot_flag = 1'b1; step(4);
        ot_flag = 1'b0; step(5);
        // Mixed stimulus across all windows and modes (R3 R6 R7 R9)
        cur_req = "R3 R6 mixed"; tick_div = 2;
        for (int k = 0; k < 6000; k++) begin
            if ((k % 500) == 0) begin
                ocp_len_sel = 2'($urandom_range(0, 3));
                scp_mode    = 2'($urandom_range(0, 3));
                ovp_mode    = 2'($urandom_range(0, 3));
                hiccup_off  = 8'($urandom_range(0, 7));
            end
            ilim_hit = ($urandom_range(0, 99) < 97);
            uv_flag  = ($urandom_range(0, 99) < 2);
            ov_flag  = ($urandom_range(0, 999) < 5);
            ot_flag  = ($urandom_range(0, 999) < 3);
            ss_done  = ($urandom_range(0, 99) < 60);
            en       = ($urandom_range(0, 999) < 997);
            step(1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule